// File: doc/BRIEF.md
# Inter-access bus idle inserter

This block sits between the local bus request queue and the external bus sequencer. It keeps a record of the chip-select area, the direction and the multiplexed-area flag of the last access that completed. Before the sequencer is told to start a new access, the block classifies the transition from that record to the pending access. It then holds the start strobe low until at least the programmed number of idle cycles has gone by since the completion.

Every area has its own five idle settings, and the settings of the area that was just accessed decide the gap. Each setting is a 3-bit code. A read followed by another access to a multiplexed address/data area always leaves at least one idle cycle. Accesses of 8 or 16 bytes go out as 4-byte beats, and the same gap rule applies between the beats. When an external master asks for the bus, the pending gap runs out first and then the grant is raised. After the bus comes back, the access record is invalid. CPU accesses and dual-address DMA transfers go through the same request port and follow the same rules.

Top module: `bus_idle_gap`

## Requirements
- R1: After reset `seq_start`, `req_ready` and `ext_bgnt` are low. The access record is invalid, so the first request starts in the same cycle it is presented.
- R2: A setting code maps to idle cycles as follows: 0→0, 1→1, 2→2, 3→4, 4→6, 5→8, 6→10, 7→12. `cfg_idle` holds 15 bits per area, with area a at bits [15a+14:15a]. Inside an area's slice the fields are: [2:0] after a write, [5:3] read then write to another area, [8:6] read then write to the same area, [11:9] read then read to another area, [14:12] read then read to the same area.
- R3: After a completed write, the next access waits for the previous area's after-write setting, whatever its area or direction.
- R4: After a completed read, a write waits for the previous area's read-then-write setting. The different-area field is used when the areas differ and the same-area field when they match.
- R5: After a completed read, a read waits for the previous area's read-then-read setting, with the same different-area/same-area choice as R4.
- R6: The gap is a minimum. If the completion (`seq_done` high) is in cycle D and the gap is g, then a request that is already waiting starts in cycle D+g+1. A request that arrives later starts in the cycle it arrives.
- R7: If the previous access was a read to a multiplexed area (`req_mux`=1) and the next access is also to a multiplexed area, the gap is at least 1 even when the setting gives 0.
- R8: `req_size` 0 gives one beat, 1 gives two beats, and 2 or 3 give four beats. Each beat is one `seq_start` pulse and is finished by one `seq_done`. The gap between beats follows R3/R5/R7 with the same area and direction, and no further start follows the last beat.
- R9: While no access is in progress, a high `ext_breq` raises `ext_bgnt` one cycle after the gap is met. The release gap is the after-write setting after a write, or the read-then-write different-area setting after a read. `ext_bgnt` stays high while `ext_breq` is high and falls in the cycle after `ext_breq` drops.
- R10: Once the bus is regained, the access record is invalid and the next access starts with no gap.
- R11: While `ext_breq` is high in the idle state, no pending request is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle | input | 15*N_AREA | Per-area idle setting codes |
| req_valid | input | 1 | Request pending |
| req_ready | output | 1 | Request accepted (first beat starts) |
| req_area | input | AW | Request chip-select area |
| req_wr | input | 1 | Request is a write |
| req_size | input | 2 | Access size code |
| req_mux | input | 1 | Request targets a multiplexed area |
| seq_start | output | 1 | Start one 4-byte beat |
| seq_area | output | AW | Area of the beat being started |
| seq_wr | output | 1 | Direction of the beat being started |
| seq_mux | output | 1 | Multiplexed flag of the beat being started |
| seq_done | input | 1 | Sequencer finished the current beat |
| ext_breq | input | 1 | External master requests the bus |
| ext_bgnt | output | 1 | Bus granted to the external master |

## Verification
The bench builds the block with N_AREA=2. With that setting, every previous/next pairing of same area, other area, read and write can be reached in a short run. It rotates all eight codes through every field of both areas, so every transition class meets every gap length, and checks each measured gap against the arithmetic mapping. The same small setup also runs the late-request, multiplexed-floor, beat-split and bus-release sequences.

// File: rtl/bus_idle_gap_pkg.sv
package bus_idle_gap_pkg;
  localparam int CODE_W  = 3;
  localparam int N_FIELD = 5;
  localparam int SET_W   = CODE_W * N_FIELD;
  localparam int GAP_W   = 4;

  // field index inside one area's slice
  localparam int FLD_AFTER_WR = 0;
  localparam int FLD_RW_OTHER = 1;
  localparam int FLD_RW_SAME  = 2;
  localparam int FLD_RR_OTHER = 3;
  localparam int FLD_RR_SAME  = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_BEAT  = 2'd2,
    ST_GRANT = 2'd3
  } gap_state_t;

  // 0,1,2 map to themselves; above that, two cycles per step
  function automatic logic [GAP_W-1:0] code_to_gap(input logic [CODE_W-1:0] code);
    if (code <= 3'd2) return {1'b0, code};
    else              return {code - 3'd1, 1'b0};
  endfunction
endpackage

// File: rtl/bus_idle_gap_rule.sv
module bus_idle_gap_rule
  import bus_idle_gap_pkg::*;
#(
  parameter int N_AREA = 4,
  parameter int AW     = 2
) (
  input  logic [N_AREA*SET_W-1:0] cfg_idle,
  input  logic                    rec_valid,
  input  logic [AW-1:0]           rec_area,
  input  logic                    rec_wr,
  input  logic                    rec_mux,
  input  logic [AW-1:0]           nxt_area,
  input  logic                    nxt_wr,
  input  logic                    nxt_mux,
  input  logic                    release_chk,
  output logic [GAP_W-1:0]        need
);
  int                 fsel;
  logic               same_area;
  logic               mux_floor;
  logic [GAP_W-1:0]   base_gap;
  logic [GAP_W-1:0]   area_gap [N_AREA];

  assign same_area = (rec_area == nxt_area);

  // transition classifier
  always_comb begin
    if (rec_wr)           fsel = FLD_AFTER_WR;
    else if (release_chk) fsel = FLD_RW_OTHER;
    else if (nxt_wr)      fsel = same_area ? FLD_RW_SAME : FLD_RW_OTHER;
    else                  fsel = same_area ? FLD_RR_SAME : FLD_RR_OTHER;
  end

  // decode the selected field for every area, then pick the previous one
  generate
    for (genvar a = 0; a < N_AREA; a++) begin : g_area
      assign area_gap[a] = code_to_gap(cfg_idle[a*SET_W + fsel*CODE_W +: CODE_W]);
    end
  endgenerate

  assign base_gap  = area_gap[rec_area];
  assign mux_floor = !rec_wr && rec_mux && nxt_mux && !release_chk;

  always_comb begin
    if (!rec_valid)                    need = '0;
    else if (mux_floor && base_gap == '0) need = GAP_W'(1);
    else                               need = base_gap;
  end
endmodule

// File: rtl/bus_idle_gap_timer.sv
module bus_idle_gap_timer
  import bus_idle_gap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [GAP_W-1:0] elapsed
);
  logic [GAP_W-1:0] elapsed_nx;

  always_comb begin
    elapsed_nx = elapsed;
    if (clr)                        elapsed_nx = '0;
    else if (adv && elapsed != '1)  elapsed_nx = elapsed + GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elapsed <= '0;
    else        elapsed <= elapsed_nx;
  end
endmodule

// File: rtl/bus_idle_gap.sv
module bus_idle_gap
  import bus_idle_gap_pkg::*;
#(
  parameter int N_AREA = 4,
  parameter int AW     = $clog2(N_AREA)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_AREA*SET_W-1:0] cfg_idle,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_area,
  input  logic                    req_wr,
  input  logic [1:0]              req_size,
  input  logic                    req_mux,
  output logic                    seq_start,
  output logic [AW-1:0]           seq_area,
  output logic                    seq_wr,
  output logic                    seq_mux,
  input  logic                    seq_done,
  input  logic                    ext_breq,
  output logic                    ext_bgnt
);
  logic             rst_meta, rst_sync_n;
  gap_state_t       state, state_nx;
  logic             start_c, load_c, beat_c, done_c, drop_c;
  logic [AW-1:0]    cur_area;
  logic             cur_wr, cur_mux;
  logic [1:0]       beats_left, beats_nx;
  logic             rec_valid, rec_wr, rec_mux;
  logic [AW-1:0]    rec_area;
  logic [GAP_W-1:0] need, elapsed;
  logic             gap_met, release_chk;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign release_chk = (state == ST_IDLE) && ext_breq;
  assign seq_area    = (state == ST_IDLE) ? req_area : cur_area;
  assign seq_wr      = (state == ST_IDLE) ? req_wr   : cur_wr;
  assign seq_mux     = (state == ST_IDLE) ? req_mux  : cur_mux;

  bus_idle_gap_rule #(.N_AREA(N_AREA), .AW(AW)) u_rule (
    .cfg_idle    (cfg_idle),
    .rec_valid   (rec_valid),
    .rec_area    (rec_area),
    .rec_wr      (rec_wr),
    .rec_mux     (rec_mux),
    .nxt_area    (seq_area),
    .nxt_wr      (seq_wr),
    .nxt_mux     (seq_mux),
    .release_chk (release_chk),
    .need        (need)
  );

  bus_idle_gap_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (done_c),
    .adv     (state != ST_BUSY),
    .elapsed (elapsed)
  );

  assign gap_met = (elapsed >= need);

  // next-state logic
  always_comb begin
    state_nx = state;
    start_c  = 1'b0;
    load_c   = 1'b0;
    beat_c   = 1'b0;
    done_c   = 1'b0;
    drop_c   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (ext_breq) begin
          if (gap_met) state_nx = ST_GRANT;
        end else if (req_valid && gap_met) begin
          start_c  = 1'b1;
          load_c   = 1'b1;
          state_nx = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (seq_done) begin
          done_c   = 1'b1;
          state_nx = (beats_left != 2'd0) ? ST_BEAT : ST_IDLE;
        end
      end
      ST_BEAT: begin
        if (gap_met) begin
          start_c  = 1'b1;
          beat_c   = 1'b1;
          state_nx = ST_BUSY;
        end
      end
      ST_GRANT: begin
        if (!ext_breq) begin
          drop_c   = 1'b1;
          state_nx = ST_IDLE;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    beats_nx = beats_left;
    if (load_c) begin
      case (req_size)
        2'd0:    beats_nx = 2'd0;
        2'd1:    beats_nx = 2'd1;
        default: beats_nx = 2'd3;
      endcase
    end else if (beat_c) begin
      beats_nx = beats_left - 2'd1;
    end
  end

  assign seq_start = start_c;
  assign req_ready = load_c;
  assign ext_bgnt  = (state == ST_GRANT);

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state      <= ST_IDLE;
      beats_left <= 2'd0;
      cur_area   <= '0;
      cur_wr     <= 1'b0;
      cur_mux    <= 1'b0;
      rec_valid  <= 1'b0;
      rec_area   <= '0;
      rec_wr     <= 1'b0;
      rec_mux    <= 1'b0;
    end else begin
      state      <= state_nx;
      beats_left <= beats_nx;
      if (load_c) begin
        cur_area <= req_area;
        cur_wr   <= req_wr;
        cur_mux  <= req_mux;
      end
      if (done_c) begin
        rec_valid <= 1'b1;
        rec_area  <= cur_area;
        rec_wr    <= cur_wr;
        rec_mux   <= cur_mux;
      end else if (drop_c) begin
        rec_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bus_idle_gap_chk.sv
module bus_idle_gap_chk
  import bus_idle_gap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             seq_start,
  input logic             seq_mux,
  input logic             ext_breq,
  input logic             ext_bgnt,
  input logic             rec_valid,
  input logic             rec_wr,
  input logic             rec_mux,
  input logic [GAP_W-1:0] elapsed,
  input logic [GAP_W-1:0] need
);
  AST_START_GAP_MET: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> elapsed >= need); // R6

  AST_NO_START_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    ext_bgnt |-> !seq_start); // R9

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ext_bgnt && ext_breq |=> ext_bgnt); // R9

  AST_GRANT_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_bgnt) |-> $past(ext_breq)); // R9

  AST_START_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start); // R8

  AST_INVALID_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |-> need == '0); // R10

  AST_MUX_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_wr && rec_mux && seq_mux && !ext_breq) |-> need != '0); // R7

  AST_NEED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    need <= GAP_W'(12)); // R2
endmodule

bind bus_idle_gap bus_idle_gap_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .seq_start (seq_start),
  .seq_mux   (seq_mux),
  .ext_breq  (ext_breq),
  .ext_bgnt  (ext_bgnt),
  .rec_valid (rec_valid),
  .rec_wr    (rec_wr),
  .rec_mux   (rec_mux),
  .elapsed   (elapsed),
  .need      (need)
);

// File: tb/bus_idle_gap_bench.sv
`timescale 1ns/100ps
module bus_idle_gap_bench;
  localparam int NA = 2;
  localparam int SW = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NA*SW-1:0] cfg;
  logic          req_valid, req_ready, req_wr, req_mux;
  logic [0:0]    req_area;
  logic [1:0]    req_size;
  logic          seq_start, seq_wr, seq_mux, seq_done;
  logic [0:0]    seq_area;
  logic          ext_breq, ext_bgnt;

  always #2 clk = ~clk;

  bus_idle_gap #(.N_AREA(NA)) u_bus_idle_gap (
    .clk(clk), .rst_n(rst_n), .cfg_idle(cfg),
    .req_valid(req_valid), .req_ready(req_ready), .req_area(req_area),
    .req_wr(req_wr), .req_size(req_size), .req_mux(req_mux),
    .seq_start(seq_start), .seq_area(seq_area), .seq_wr(seq_wr),
    .seq_mux(seq_mux), .seq_done(seq_done),
    .ext_breq(ext_breq), .ext_bgnt(ext_bgnt)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  int last_done = 0;
  int wait0;
  int gaps [4];
  bit tmo;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int dec(input int c);
    return (c <= 2) ? c : (c - 1) * 2;
  endfunction

  function automatic int fld(input int a, input int f);
    return int'(cfg[a*SW + f*3 +: 3]);
  endfunction

  function automatic int exp_gap(input int pa, input bit pw, input bit pm,
                                 input int na, input bit nw, input bit nm);
    int f, g;
    if (pw)      f = 0;
    else if (nw) f = (pa == na) ? 2 : 1;
    else         f = (pa == na) ? 4 : 3;
    g = dec(fld(pa, f));
    if (!pw && pm && nm && g < 1) g = 1;
    return g;
  endfunction

  task automatic set_pattern(input int k);
    for (int a = 0; a < NA; a++)
      for (int f = 0; f < 5; f++)
        cfg[a*SW + f*3 +: 3] = 3'((k + 3*f + 5*a) % 8);
  endtask

  // entered and left on a falling edge with seq_done low
  task automatic do_acc(input int a, input bit w, input int sz, input bit m, input int dly);
    int nb, t0, guard;
    nb  = (sz == 0) ? 1 : ((sz == 1) ? 2 : 4);
    tmo = 1'b0;
    repeat (dly) @(negedge clk);
    req_area = 1'(a); req_wr = w; req_size = 2'(sz); req_mux = m; req_valid = 1'b1;
    t0 = cyc;
    for (int b = 0; b < nb; b++) begin
      guard = 0;
      #1;
      while (!seq_start && guard < 200) begin
        @(negedge clk); #1; guard++;
      end
      if (guard >= 200) begin
        tmo = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        return;
      end
      if (b == 0) wait0 = cyc - t0;
      gaps[b] = cyc - last_done - 1;
      @(negedge clk);
      req_valid = 1'b0; seq_done = 1'b1; last_done = cyc;
      @(negedge clk);
      seq_done = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int e, gc, guard;
    bit seen, extra;
    rst_n = 1'b0; cfg = '0; req_valid = 1'b0; req_area = '0; req_wr = 1'b0;
    req_size = 2'd0; req_mux = 1'b0; seq_done = 1'b0; ext_breq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(seq_start == 1'b0, "R1 start after reset", seq_start, 0);
    chk(req_ready == 1'b0, "R1 ready after reset", req_ready, 0);
    chk(ext_bgnt == 1'b0, "R1 grant after reset", ext_bgnt, 0);
    @(negedge clk);

    // first access: record invalid, starts at once despite large codes
    set_pattern(7);
    do_acc(0, 1'b1, 0, 1'b0, 0);
    chk(!tmo && wait0 == 0, "R1 first access wait", wait0, 0);

    // sweep of codes over every transition class
    for (int k = 0; k < 8; k++) begin
      set_pattern(k);
      for (int pa = 0; pa < NA; pa++)
        for (int pw = 0; pw < 2; pw++)
          for (int na = 0; na < NA; na++)
            for (int nw = 0; nw < 2; nw++) begin
              do_acc(pa, 1'(pw), 0, 1'b0, 0);
              do_acc(na, 1'(nw), 0, 1'b0, 0);
              e = exp_gap(pa, 1'(pw), 1'b0, na, 1'(nw), 1'b0);
              if (pw != 0)
                chk(!tmo && gaps[0] == e, "R2,R3 after write", gaps[0], e);
              else if (nw != 0)
                chk(!tmo && gaps[0] == e, "R2,R4 read to write", gaps[0], e);
              else
                chk(!tmo && gaps[0] == e, "R2,R5 read to read", gaps[0], e);
            end
    end

    // minimum only: late request is not delayed further
    set_pattern(7);
    do_acc(0, 1'b0, 0, 1'b0, 0);
    e = exp_gap(0, 1'b0, 1'b0, 1, 1'b0, 1'b0);
    do_acc(1, 1'b0, 0, 1'b0, e + 3);
    chk(!tmo && wait0 == 0, "R6 late request wait", wait0, 0);
    chk(gaps[0] == e + 3, "R6 late request gap", gaps[0], e + 3);

    // multiplexed-area floor
    cfg = '0;
    do_acc(0, 1'b0, 0, 1'b1, 0); do_acc(1, 1'b0, 0, 1'b1, 0);
    chk(gaps[0] == 1, "R7 mux read to mux read", gaps[0], 1);
    do_acc(1, 1'b1, 0, 1'b1, 0);
    chk(gaps[0] == 1, "R7 mux read to mux write", gaps[0], 1);
    do_acc(0, 1'b0, 0, 1'b1, 0);
    chk(gaps[0] == 0, "R7 mux write to mux read", gaps[0], 0);
    do_acc(0, 1'b0, 0, 1'b0, 0);
    chk(gaps[0] == 0, "R7 mux read to plain read", gaps[0], 0);
    do_acc(0, 1'b0, 0, 1'b1, 0);
    chk(gaps[0] == 0, "R7 plain read to mux read", gaps[0], 0);
    cfg[4*3 +: 3] = 3'd2;
    do_acc(0, 1'b0, 0, 1'b1, 0);
    chk(gaps[0] == 2, "R7 larger setting wins", gaps[0], 2);

    // wide accesses split into beats
    set_pattern(3);
    for (int sz = 1; sz < 4; sz++)
      for (int w = 0; w < 2; w++)
        for (int m = 0; m < 2; m++) begin
          do_acc(1, 1'(w), sz, 1'(m), 0);
          chk(!tmo, "R8 beat count reached", tmo, 0);
          e = exp_gap(1, 1'(w), 1'(m), 1, 1'(w), 1'(m));
          for (int b = 1; b < ((sz == 1) ? 2 : 4); b++)
            chk(gaps[b] == e, "R8 gap between beats", gaps[b], e);
          extra = 1'b0;
          repeat (4) begin
            #1; if (seq_start) extra = 1'b1;
            @(negedge clk);
          end
          chk(!extra, "R8 no start after last beat", extra, 0);
        end

    // bus release after the gap, then no gap on return
    for (int pw = 0; pw < 2; pw++) begin
      set_pattern(5 + pw);
      do_acc(0, 1'(pw), 0, 1'b0, 0);
      e = (pw != 0) ? dec(fld(0, 0)) : dec(fld(0, 1));
      ext_breq = 1'b1;
      req_area = 1'b1; req_wr = 1'b0; req_size = 2'd0; req_mux = 1'b0; req_valid = 1'b1;
      seen = 1'b0; guard = 0;
      #1;
      while (!ext_bgnt && guard < 100) begin
        if (seq_start) seen = 1'b1;
        @(negedge clk); #1; guard++;
      end
      gc = cyc;
      chk(gc == last_done + e + 2, "R9 grant after gap", gc - last_done, e + 2);
      chk(!seen, "R11 no start while bus requested", seen, 0);
      repeat (3) @(negedge clk);
      #1;
      chk(ext_bgnt == 1'b1, "R9 grant held", ext_bgnt, 1);
      chk(seq_start == 1'b0, "R11 pending request held off", seq_start, 0);
      @(negedge clk);
      ext_breq = 1'b0;
      @(negedge clk);
      #1;
      chk(ext_bgnt == 1'b0, "R9 grant dropped", ext_bgnt, 0);
      chk(seq_start == 1'b1, "R10 no gap after regain", seq_start, 1);
      @(negedge clk);
      req_valid = 1'b0; seq_done = 1'b1; last_done = cyc;
      @(negedge clk);
      seq_done = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule